// File: doc/BRIEF.md
# Eight-Channel Output Compare Timer

This block holds one free-running 16-bit time base, advanced by a power-of-two prescaler, and eight compare channels that watch it. Software reads the time base, adds a delay, and writes the sum into a channel's compare register. When the time base reaches that value on a channel marked for output compare, the channel raises its status flag. It also applies its programmed pin action (toggle, drive low or drive high) to its own output pin. A single interrupt line is the OR of all flags whose interrupt enable is set.

Two extra paths act on the pins. A force write makes the selected channels perform their pin action at the next time base tick, without a match. Channel 7 carries a mask and a data byte: when channel 7 matches, every selected pin whose mask bit is set takes the data bit. On that tick this beats the pin's own compare or force action. Flags clear by writing ones to the flag register. In fast-clear mode they also clear when the channel's compare register is read.

Top module: `oc_timer`

## Requirements
- R1: Register map (word address): 0 control, 1 time base (read only), 2 channel select, 3 pin actions, 4 interrupt enables, 5 flags, 6 force (write only, reads 0), 7 channel-7 mask, 8 channel-7 data, 16+n compare register of channel n. Control bit 0 runs the time base, bit 1 selects fast-clear mode, and bits 4:2 hold the prescale code c.
- R2: While running, the time base advances by one every 2^c clock cycles (code 3 gives divide-by-8, code 6 gives divide-by-64). With run cleared it holds its value.
- R3: A tick on which the time base equals channel n's compare value and channel n is selected sets flags bit n on the next clock edge.
- R4: Pin actions use two bits per channel, at bits 2n+1:2n of the action register: 00 leaves the pin alone, 01 toggles it, 10 drives it to 0, and 11 drives it to 1. The action is applied on the same edge that sets the flag.
- R5: Writing a 1 to force bit n applies channel n's pin action at the next tick. It sets no flag and requests no interrupt.
- R6: When channel 7 matches, every selected pin n whose mask bit n is set takes data bit n. This wins over that channel's own match or force on the same tick.
- R7: In fast-clear mode, reading compare register n clears flag n. With fast-clear off, such a read leaves the flags unchanged.
- R8: Writing the flag register clears each flag whose written bit is 1. Bits written 0 are unchanged.
- R9: The interrupt output is high exactly when some flag and its enable bit are both set.
- R10: A pin whose channel-select bit is 0 holds its value through matches, forces and channel-7 overrides, and its flag is not set.
- R11: After reset all registers, the time base, all pins and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 5 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| pins | output | 8 | Channel output pins |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the same-tick collision between a channel-7 match and another channel's own match. Software can only aim compare values at a running time base that it cannot preset. The bench therefore reads the time base once and writes the same future value into channel 7 and channel 3. It sets the two outcomes to conflict, with the own action driving high and the override data driving low, and repeats the case with the mask cleared to show the own action then wins. A masked pin with no action of its own is also checked. Force and match sweeps run over every channel and every action code, with the expected pin byte kept in an arithmetic model in the bench.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int NCH    = 8;
    localparam int ADDR_W = 5;
    localparam int PS_W   = 3;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } oc_act_e;

    typedef struct packed {
        logic [PS_W-1:0] ps_code;
        logic            fast_clr;
        logic            run;
    } oc_ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 5'd1;
    localparam logic [ADDR_W-1:0] A_SEL  = 5'd2;
    localparam logic [ADDR_W-1:0] A_ACT  = 5'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 5'd4;
    localparam logic [ADDR_W-1:0] A_FLG  = 5'd5;
    localparam logic [ADDR_W-1:0] A_FRC  = 5'd6;
    localparam logic [ADDR_W-1:0] A_MSK7 = 5'd7;
    localparam logic [ADDR_W-1:0] A_DAT7 = 5'd8;
    localparam logic [ADDR_W-1:0] A_CMP  = 5'd16;

    function automatic logic apply_act(oc_act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/oc_tick_gen.sv
module oc_tick_gen
    import oc_timer_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int PSW = PS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [PSW-1:0] ps_code,
    output logic           tick,
    output logic [CW-1:0]  cnt
);
    localparam int PRE_W = (1 << PSW) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;

    // divide-by-2^code: tick when the low code bits of pre_q are all ones
    assign pre_mask = (PRE_W'(1) << ps_code) - PRE_W'(1);
    assign tick     = run && ((pre_q & pre_mask) == pre_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt   <= '0;
        end else begin
            if (run)  pre_q <= pre_q + PRE_W'(1);
            if (tick) cnt   <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_timer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          sel,
    input  logic [1:0]    act,
    input  logic          force_req,
    input  logic          ovr_en,
    input  logic          ovr_val,
    input  logic          clr,
    output logic          hit,
    output logic          flag,
    output logic          pin
);
    assign hit = tick && sel && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (hit)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (tick && sel) begin
            if (ovr_en)                pin <= ovr_val;
            else if (hit || force_req) pin <= apply_act(oc_act_e'(act), pin);
        end
    end
endmodule

// File: rtl/oc_timer.sv
module oc_timer
    import oc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NCH-1:0]    pins,
    output logic              irq
);
    localparam int CTRL_W = $bits(oc_ctrl_t);
    localparam int IDX_W  = $clog2(NCH);

    oc_ctrl_t                   ctrl_q;
    logic [NCH-1:0]             sel_q, ien_q, msk7_q, dat7_q, frc_q;
    logic [2*NCH-1:0]           act_q;
    logic [NCH-1:0][CNT_W-1:0]  cmp_q;
    logic [NCH-1:0]             hit_v, flag_v, clr_v;
    logic                       tick;
    logic [CNT_W-1:0]           cnt;
    logic                       cmp_sel;

    assign cmp_sel = (addr >= A_CMP) && (addr < A_CMP + ADDR_W'(NCH));

    oc_tick_gen #(.CW(CNT_W), .PSW(PS_W)) u_tick (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .ps_code(ctrl_q.ps_code),
        .tick(tick), .cnt(cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            ien_q  <= '0;
            msk7_q <= '0;
            dat7_q <= '0;
            act_q  <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: ctrl_q <= oc_ctrl_t'(wdata[CTRL_W-1:0]);
                A_SEL:  sel_q  <= wdata[NCH-1:0];
                A_ACT:  act_q  <= wdata[2*NCH-1:0];
                A_IEN:  ien_q  <= wdata[NCH-1:0];
                A_MSK7: msk7_q <= wdata[NCH-1:0];
                A_DAT7: dat7_q <= wdata[NCH-1:0];
                default: if (cmp_sel) cmp_q[addr[IDX_W-1:0]] <= wdata;
            endcase
        end
    end

    // pending forces wait for the next tick; a write in a tick cycle waits for the one after
    always_ff @(posedge clk) begin
        if (rst) frc_q <= '0;
        else     frc_q <= (tick ? '0 : frc_q) |
                          ((wr_en && addr == A_FRC) ? wdata[NCH-1:0] : '0);
    end

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            assign clr_v[n] = (wr_en && addr == A_FLG && wdata[n]) ||
                              (rd_en && ctrl_q.fast_clr && addr == A_CMP + ADDR_W'(n));
            oc_channel #(.CW(CNT_W)) u_ch (
                .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp(cmp_q[n]),
                .sel(sel_q[n]), .act(act_q[2*n +: 2]), .force_req(frc_q[n]),
                .ovr_en(hit_v[NCH-1] && msk7_q[n]), .ovr_val(dat7_q[n]),
                .clr(clr_v[n]), .hit(hit_v[n]), .flag(flag_v[n]), .pin(pins[n])
            );
        end
    endgenerate

    assign irq = |(flag_v & ien_q);

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = CNT_W'(ctrl_q);
            A_CNT:  rdata = cnt;
            A_SEL:  rdata = CNT_W'(sel_q);
            A_ACT:  rdata = CNT_W'(act_q);
            A_IEN:  rdata = CNT_W'(ien_q);
            A_FLG:  rdata = CNT_W'(flag_v);
            A_MSK7: rdata = CNT_W'(msk7_q);
            A_DAT7: rdata = CNT_W'(dat7_q);
            default: if (cmp_sel) rdata = cmp_q[addr[IDX_W-1:0]];
        endcase
    end
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic [CW-1:0]       cnt,
    input logic [NCH-1:0][CW-1:0] cmp,
    input logic [NCH-1:0]      sel,
    input logic [NCH-1:0]      msk7,
    input logic [NCH-1:0]      dat7,
    input logic [NCH-1:0]      flags,
    input logic [NCH-1:0]      ien,
    input logic [NCH-1:0]      pins,
    input logic                irq
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == $past(cnt) + CW'(1));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    // R4
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pins));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags & ien) != '0);

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_a
            // R3
            flag_set_chk: assert property (@(posedge clk) disable iff (rst)
                tick && sel[n] && cnt == cmp[n] |=> flags[n]);
            // R10
            unsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !sel[n] |=> pins[n] == $past(pins[n]));
            // R6
            ovr_win_chk: assert property (@(posedge clk) disable iff (rst)
                tick && sel[NCH-1] && cnt == cmp[NCH-1] && msk7[n] && sel[n]
                |=> pins[n] == $past(dat7[n]));
        end
    endgenerate
endmodule

bind oc_timer oc_timer_chk #(.NCH(NCH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp(cmp_q), .sel(sel_q),
    .msk7(msk7_q), .dat7(dat7_q), .flags(flag_v), .ien(ien_q), .pins(pins), .irq(irq)
);

// File: tb/oc_timer_tb_top.sv
module oc_timer_tb_top;
    import oc_timer_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [NCH-1:0]    pins;
    logic              irq;

    int total = 0, bad = 0;
    logic [15:0] act_sh = '0;
    logic [7:0]  exp_pins = '0;
    logic [15:0] v, c0, c1;

    always #10 clk = ~clk;

    oc_timer dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .pins(pins), .irq(irq));

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_act(int n, logic [1:0] code);
        act_sh[2*n +: 2] = code;
        wr(A_ACT, act_sh);
    endtask

    task automatic wait_cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic next_pin(logic [1:0] code, logic cur);
        return code == 2'b01 ? ~cur : code == 2'b10 ? 1'b0 : code == 2'b11 ? 1'b1 : cur;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R11: reset state
        rd(A_CNT, v);  chk("R11 count", v, 16'h0);
        rd(A_FLG, v);  chk("R11 flags", v, 16'h0);
        rd(A_CMP + 5'd7, v); chk("R11 cmp7", v, 16'h0);
        chk("R11 pins", {8'h0, pins}, 16'h0);
        chk("R11 irq", {15'h0, irq}, 16'h0);

        for (int n = 0; n < 8; n++) wr(A_CMP + 5'(n), 16'h8000);
        wr(A_SEL, 16'h00FF);
        wr(A_CTRL, 16'h0001);

        // R4 R5: force sweep over every channel and every action code
        for (int n = 0; n < 8; n++) begin
            logic [1:0] seq [5];
            seq = '{2'b11, 2'b10, 2'b01, 2'b01, 2'b00};
            for (int k = 0; k < 5; k++) begin
                set_act(n, seq[k]);
                wr(A_FRC, 16'(1 << n));
                wait_cyc(3);
                exp_pins[n] = next_pin(seq[k], exp_pins[n]);
                chk("R5 forced action", {8'h0, pins}, {8'h0, exp_pins});
            end
        end
        rd(A_FLG, v); chk("R5 force sets no flag", v, 16'h0);
        chk("R5 force no irq", {15'h0, irq}, 16'h0);

        // R10: deselected channel ignores force and match
        wr(A_SEL, 16'h00BF);
        set_act(6, 2'b01);
        wr(A_FRC, 16'h0040);
        wait_cyc(3);
        chk("R10 force on deselected pin", {8'h0, pins}, {8'h0, exp_pins});
        rd(A_CNT, c0);
        wr(A_CMP + 5'd6, c0 + 16'd30);
        wait_cyc(45);
        rd(A_FLG, v); chk("R10 no flag when deselected", v, 16'h0);
        chk("R10 no pin change on match", {8'h0, pins}, {8'h0, exp_pins});
        wr(A_SEL, 16'h00FF);

        // R3 R4: match sweep with toggle on every channel
        wr(A_ACT, 16'h5555); act_sh = 16'h5555;
        for (int n = 0; n < 8; n++) begin
            rd(A_CNT, c0);
            wr(A_CMP + 5'(n), c0 + 16'd30);
            wait_cyc(15);
            rd(A_FLG, v); chk("R3 flag before match", v, 16'((1 << n) - 1));
            wait_cyc(30);
            rd(A_FLG, v); chk("R3 flag after match", v, 16'((2 << n) - 1));
            exp_pins[n] = ~exp_pins[n];
            chk("R4 toggle on match", {8'h0, pins}, {8'h0, exp_pins});
        end

        // R7 R8 R9
        wr(A_CTRL, 16'h0003);
        rd(A_CMP + 5'd2, v); wait_cyc(1);
        rd(A_FLG, v); chk("R7 fast clear read", v, 16'h00FB);
        wr(A_CTRL, 16'h0001);
        rd(A_CMP + 5'd3, v); wait_cyc(1);
        rd(A_FLG, v); chk("R7 read without fast clear", v, 16'h00FB);
        wr(A_FLG, 16'h0000);
        rd(A_FLG, v); chk("R8 zero write keeps flags", v, 16'h00FB);
        wr(A_FLG, 16'h0010);
        rd(A_FLG, v); chk("R8 one write clears", v, 16'h00EB);
        chk("R9 irq all disabled", {15'h0, irq}, 16'h0);
        wr(A_IEN, 16'h0004); wait_cyc(1);
        chk("R9 irq enable on clear flag", {15'h0, irq}, 16'h0);
        wr(A_IEN, 16'h0001); wait_cyc(1);
        chk("R9 irq raised", {15'h0, irq}, 16'h1);
        wr(A_FLG, 16'h00FF); wait_cyc(1);
        chk("R9 irq dropped", {15'h0, irq}, 16'h0);

        // R6: channel 7 override against channel 3 own match
        set_act(3, 2'b11); set_act(7, 2'b11); set_act(5, 2'b10);
        wr(A_FRC, 16'h0028); wait_cyc(3);
        exp_pins[3] = 1'b1; exp_pins[5] = 1'b0;
        set_act(5, 2'b00);
        set_act(3, 2'b11);
        wr(A_MSK7, 16'h0028); wr(A_DAT7, 16'h0020);
        rd(A_CNT, c0);
        wr(A_CMP + 5'd3, c0 + 16'd40); wr(A_CMP + 5'd7, c0 + 16'd40);
        wait_cyc(50);
        exp_pins[3] = 1'b0; exp_pins[5] = 1'b1; exp_pins[7] = 1'b1;
        chk("R6 override beats own match", {8'h0, pins}, {8'h0, exp_pins});
        wr(A_MSK7, 16'h0000);
        rd(A_CNT, c0);
        wr(A_CMP + 5'd3, c0 + 16'd40); wr(A_CMP + 5'd7, c0 + 16'd40);
        wait_cyc(50);
        exp_pins[3] = 1'b1;
        chk("R6 own action when unmasked", {8'h0, pins}, {8'h0, exp_pins});

        // R2: stop and prescale
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, c0); wait_cyc(20); rd(A_CNT, c1);
        chk("R2 halted count", c1, c0);
        wr(A_CTRL, 16'h000D);
        rd(A_CNT, c0); wait_cyc(799); rd(A_CNT, c1);
        v = c1 - c0;
        chk("R2 divide by 8", {15'h0, (v >= 16'd99 && v <= 16'd101)}, 16'h1);
        wr(A_CTRL, 16'h0019);
        rd(A_CNT, c0); wait_cyc(1279); rd(A_CNT, c1);
        v = c1 - c0;
        chk("R2 divide by 64", {15'h0, (v >= 16'd19 && v <= 16'd21)}, 16'h1);
        rd(A_CTRL, v); chk("R1 control readback", v, 16'h0019);
        rd(A_FRC, v);  chk("R1 force reads zero", v, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule